// File: doc/BRIEF.md
# Direct-Mapped Page Translation Cache Front End

This block sits between a core's address-generation stage and a page-table walker. It holds a small direct-mapped set of recent linear-to-physical page translations for a 32-bit address space with 4 KB pages. It accepts one lookup at a time: a linear address, a data-write flag (writes and read-modify-writes both set it), an instruction-fetch flag, the requester's privilege level and the write-protect control bit. A lookup that hits with sufficient rights returns the physical frame joined to the page offset on the next cycle.

When a cached entry is absent, or does not grant the requested right, or has never been used for a write while a write is requested, the block does not raise a fault or patch memory. It asks the walker for a fresh translation and holds the request until the walker answers. A good answer refills the entry and completes the lookup. A faulting answer invalidates the entry and is passed back as a faulting response. A flush input drops every entry.

Top module: `tlb_front`

## Requirements
- R1: A lookup whose entry is valid, matches the frame, passes the permission rule and needs no written-bit update raises `rsp_valid` for one cycle, one clock after acceptance, with `rsp_paddr` = {cached physical frame, address bits [11:0]} and no walker request.
- R2: A lookup that misses raises `walk_req` one clock after acceptance, carrying the accepted linear address; when `walk_done` is sampled without `walk_fault`, `rsp_valid` rises on the next cycle with `rsp_paddr` = {`walk_ppf`, address bits [11:0]}.
- R3: Permission rule: a supervisor (`req_user`=0) read always passes; a supervisor write passes if the page is writable or `req_wp`=0; a user access needs the user bit; a user write also needs the writable bit. A hit that fails the rule triggers a walk, not a fault.
- R4: A data write that hits an entry whose written bit is clear triggers a walk; the refill from a data write sets the written bit, so a later write to the same page hits without a walk.
- R5: A fetch is treated as a read whatever `req_write` says: `walk_write` is 0 for it, and the refill stores the walker's access bits with the written bit clear.
- R6: A walker fault gives a response with `rsp_fault`=1 and invalidates the entry of that address, so the next lookup of that page walks.
- R7: Reset and `flush` invalidate every entry; an invalid entry matches no frame, including frame 0.
- R8: The entry index is frame bits [INDEX_BITS-1:0] (linear address bits [12+INDEX_BITS-1:12]); a page with the same index evicts the other, while other indices are untouched.
- R9: `req_ready` is low from acceptance of a walking lookup until its response; only one lookup is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_laddr | input | 32 | Linear address |
| req_write | input | 1 | Write or read-modify-write access |
| req_fetch | input | 1 | Instruction fetch |
| req_user | input | 1 | Requester privilege: 1 user, 0 supervisor |
| req_wp | input | 1 | Supervisor write-protect enable |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault | output | 1 | Response carries a walker fault |
| walk_req | output | 1 | Walk request, held until walk_done |
| walk_laddr | output | 32 | Address to walk |
| walk_write | output | 1 | Effective write flag for the walk |
| walk_fetch | output | 1 | Walk is for a fetch |
| walk_user | output | 1 | Privilege of the walked access |
| walk_wp | output | 1 | Write-protect bit of the walked access |
| walk_done | input | 1 | Walker finished |
| walk_fault | input | 1 | Walker found a fault |
| walk_ppf | input | 20 | Physical frame from the walker |
| walk_acc | input | 2 | Combined access bits {user, writable} |

## Verification
Lookups are applied as cold misses, warm hits at a new offset, writes to pages first seen by reads, accesses whose rights change in the stub's tables between lookups, and fetches carrying a write flag; the count of walker requests per lookup separates a fast hit from a forced re-walk. Supervisor writes to read-only pages with write-protect on and off separate the two halves of the permission rule. Aliasing addresses, a walker fault and a flush show which entries survive, each seen only through whether the next lookup walks.

// File: rtl/tlb_front_pkg.sv
package tlb_front_pkg;
  typedef enum logic {ST_IDLE, ST_WALK} tlb_state_e;
  localparam int ACC_W  = 3;
  localparam int ACC_US = 2;
  localparam int ACC_RW = 1;
  localparam int ACC_WR = 0;
endpackage

// File: rtl/tlb_front_perm.sv
module tlb_front_perm (
  input  logic wp,
  input  logic user,
  input  logic us,
  input  logic rw,
  input  logic is_wr,
  output logic ok
);
  localparam int TBL_N = 32;
  logic [TBL_N-1:0] allow;

  // Rule table indexed by {wp, user, us, rw, is_wr}.
  for (genvar i = 0; i < TBL_N; i++) begin : g_rule
    localparam bit B_WR   = ((i >> 0) & 1) != 0;
    localparam bit B_RW   = ((i >> 1) & 1) != 0;
    localparam bit B_US   = ((i >> 2) & 1) != 0;
    localparam bit B_USER = ((i >> 3) & 1) != 0;
    localparam bit B_WP   = ((i >> 4) & 1) != 0;
    if (B_USER) begin : g_usr
      assign allow[i] = B_US && (!B_WR || B_RW);
    end else begin : g_sup
      assign allow[i] = !B_WR || B_RW || !B_WP;
    end
  end

  assign ok = allow[{wp, user, us, rw, is_wr}];
endmodule

// File: rtl/tlb_front_array.sv
module tlb_front_array #(
  parameter int FRAME_W   = 20,
  parameter int IDX_BITS  = 4,
  localparam int TAG_W    = FRAME_W + 1,
  localparam int ENTRIES  = 1 << IDX_BITS,
  localparam int ACC_W    = tlb_front_pkg::ACC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [IDX_BITS-1:0] rd_idx,
  output logic [TAG_W-1:0]    rd_tag,
  output logic [FRAME_W-1:0]  rd_ppf,
  output logic [ACC_W-1:0]    rd_acc,
  input  logic                wr_en,
  input  logic                inv_en,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [FRAME_W-1:0]  wr_ppf,
  input  logic [ACC_W-1:0]    wr_acc
);
  // Top tag bit set: a lookup always compares with it clear, so never matches.
  localparam logic [TAG_W-1:0] TAG_NONE = {1'b1, {FRAME_W{1'b0}}};

  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [FRAME_W-1:0] ppf_q [ENTRIES];
  logic [ACC_W-1:0]   acc_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel;
    assign sel = (wr_idx == IDX_BITS'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[e] <= TAG_NONE;
      end else if (flush || (inv_en && sel)) begin
        tag_q[e] <= TAG_NONE;
      end else if (wr_en && sel) begin
        tag_q[e] <= wr_tag;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && sel) begin
        ppf_q[e] <= wr_ppf;
        acc_q[e] <= wr_acc;
      end
    end
  end

  assign rd_tag = tag_q[rd_idx];
  assign rd_ppf = ppf_q[rd_idx];
  assign rd_acc = acc_q[rd_idx];
endmodule

// File: rtl/tlb_front_ctrl.sv
module tlb_front_ctrl
  import tlb_front_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_BITS  = 4,
  localparam int FRAME_W  = ADDR_W - PAGE_BITS,
  localparam int TAG_W    = FRAME_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_laddr,
  input  logic                req_write,
  input  logic                req_fetch,
  input  logic                req_user,
  input  logic                req_wp,
  output logic                rsp_valid,
  output logic [ADDR_W-1:0]   rsp_paddr,
  output logic                rsp_fault,
  output logic                walk_req,
  output logic [ADDR_W-1:0]   walk_laddr,
  output logic                walk_write,
  output logic                walk_fetch,
  output logic                walk_user,
  output logic                walk_wp,
  input  logic                walk_done,
  input  logic                walk_fault,
  input  logic [FRAME_W-1:0]  walk_ppf,
  input  logic [1:0]          walk_acc,
  output logic [IDX_BITS-1:0] lk_idx,
  input  logic [TAG_W-1:0]    lk_tag,
  input  logic [FRAME_W-1:0]  lk_ppf,
  input  logic [ACC_W-1:0]    lk_acc,
  output logic                fill_en,
  output logic                kill_en,
  output logic [IDX_BITS-1:0] fill_idx,
  output logic [TAG_W-1:0]    fill_tag,
  output logic [FRAME_W-1:0]  fill_ppf,
  output logic [ACC_W-1:0]    fill_acc
);
  tlb_state_e          st_q, st_d;
  logic [ADDR_W-1:0]   lad_q;
  logic                wr_q, fe_q, usr_q, wp_q;
  logic                rv_q, rv_d, rf_q, rf_d;
  logic [ADDR_W-1:0]   rp_q, rp_d;

  logic accept, is_wr, hit, perm_ok, clean, fast, latch_en;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign is_wr     = req_write && !req_fetch;
  assign lk_idx    = req_laddr[PAGE_BITS +: IDX_BITS];
  assign hit       = (lk_tag == {1'b0, req_laddr[ADDR_W-1:PAGE_BITS]});
  assign clean     = !(is_wr && !lk_acc[ACC_WR]);
  assign fast      = hit && perm_ok && clean;
  assign latch_en  = accept && !fast;

  tlb_front_perm u_perm (
    .wp    (req_wp),
    .user  (req_user),
    .us    (lk_acc[ACC_US]),
    .rw    (lk_acc[ACC_RW]),
    .is_wr (is_wr),
    .ok    (perm_ok)
  );

  always_comb begin
    st_d    = st_q;
    rv_d    = 1'b0;
    rf_d    = 1'b0;
    rp_d    = rp_q;
    fill_en = 1'b0;
    kill_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (fast) begin
            rv_d = 1'b1;
            rp_d = {lk_ppf, req_laddr[PAGE_BITS-1:0]};
          end else begin
            st_d = ST_WALK;
          end
        end
      end
      ST_WALK: begin
        if (walk_done) begin
          st_d = ST_IDLE;
          rv_d = 1'b1;
          if (walk_fault) begin
            rf_d    = 1'b1;
            kill_en = 1'b1;
            rp_d    = '0;
          end else begin
            fill_en = 1'b1;
            rp_d    = {walk_ppf, lad_q[PAGE_BITS-1:0]};
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      rv_q <= 1'b0;
      rf_q <= 1'b0;
    end else begin
      st_q <= st_d;
      rv_q <= rv_d;
      rf_q <= rf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rv_d) begin
      rp_q <= rp_d;
    end
    if (latch_en) begin
      lad_q <= req_laddr;
      wr_q  <= is_wr;
      fe_q  <= req_fetch;
      usr_q <= req_user;
      wp_q  <= req_wp;
    end
  end

  assign rsp_valid  = rv_q;
  assign rsp_fault  = rf_q;
  assign rsp_paddr  = rp_q;
  assign walk_req   = (st_q == ST_WALK);
  assign walk_laddr = lad_q;
  assign walk_write = wr_q;
  assign walk_fetch = fe_q;
  assign walk_user  = usr_q;
  assign walk_wp    = wp_q;

  assign fill_idx = lad_q[PAGE_BITS +: IDX_BITS];
  assign fill_tag = {1'b0, lad_q[ADDR_W-1:PAGE_BITS]};
  assign fill_ppf = walk_ppf;
  assign fill_acc = {walk_acc, wr_q};
endmodule

// File: rtl/tlb_front.sv
module tlb_front #(
  parameter int IDX_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_laddr,
  input  logic        req_write,
  input  logic        req_fetch,
  input  logic        req_user,
  input  logic        req_wp,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic        walk_req,
  output logic [31:0] walk_laddr,
  output logic        walk_write,
  output logic        walk_fetch,
  output logic        walk_user,
  output logic        walk_wp,
  input  logic        walk_done,
  input  logic        walk_fault,
  input  logic [19:0] walk_ppf,
  input  logic [1:0]  walk_acc
);
  localparam int ADDR_W    = 32;
  localparam int PAGE_BITS = 12;
  localparam int FRAME_W   = ADDR_W - PAGE_BITS;
  localparam int TAG_W     = FRAME_W + 1;
  localparam int ACC_W     = tlb_front_pkg::ACC_W;

  logic [IDX_BITS-1:0] lk_idx, fill_idx;
  logic [TAG_W-1:0]    lk_tag, fill_tag;
  logic [FRAME_W-1:0]  lk_ppf, fill_ppf;
  logic [ACC_W-1:0]    lk_acc, fill_acc;
  logic                fill_en, kill_en;

  tlb_front_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_BITS(IDX_BITS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .req_write(req_write), .req_fetch(req_fetch), .req_user(req_user),
    .req_wp(req_wp),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .walk_req(walk_req), .walk_laddr(walk_laddr), .walk_write(walk_write),
    .walk_fetch(walk_fetch), .walk_user(walk_user), .walk_wp(walk_wp),
    .walk_done(walk_done), .walk_fault(walk_fault), .walk_ppf(walk_ppf),
    .walk_acc(walk_acc),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_ppf(lk_ppf), .lk_acc(lk_acc),
    .fill_en(fill_en), .kill_en(kill_en), .fill_idx(fill_idx),
    .fill_tag(fill_tag), .fill_ppf(fill_ppf), .fill_acc(fill_acc)
  );

  tlb_front_array #(
    .FRAME_W(FRAME_W), .IDX_BITS(IDX_BITS)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_ppf(lk_ppf), .rd_acc(lk_acc),
    .wr_en(fill_en), .inv_en(kill_en), .wr_idx(fill_idx),
    .wr_tag(fill_tag), .wr_ppf(fill_ppf), .wr_acc(fill_acc)
  );
endmodule

// File: rtl/tlb_front_chk.sv
module tlb_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic        walk_req,
  input logic [31:0] walk_laddr,
  input logic        walk_write,
  input logic        walk_fetch,
  input logic        walk_done,
  input logic        walk_fault
);
  a_r9_busy_while_walking: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !req_ready);

  a_r1_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(walk_req && walk_done)));

  a_r2_walk_held: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !walk_done) |=> (walk_req && $stable(walk_laddr)));

  a_r6_fault_from_walker: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> $past(walk_req && walk_done && walk_fault));

  a_r5_fetch_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && walk_fetch) |-> !walk_write);
endmodule

bind tlb_front tlb_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .walk_req(walk_req),
  .walk_laddr(walk_laddr), .walk_write(walk_write), .walk_fetch(walk_fetch),
  .walk_done(walk_done), .walk_fault(walk_fault)
);

// File: tb/tb_tlb_front.sv
`timescale 1ns/1ps
module tb_tlb_front;
  logic        clk = 1'b0;
  logic        rst_n, flush;
  logic        req_valid, req_ready, req_write, req_fetch, req_user, req_wp;
  logic [31:0] req_laddr, rsp_paddr, walk_laddr;
  logic        rsp_valid, rsp_fault;
  logic        walk_req, walk_write, walk_fetch, walk_user, walk_wp;
  logic        walk_done, walk_fault;
  logic [19:0] walk_ppf;
  logic [1:0]  walk_acc;

  int n_chk = 0, n_bad = 0;
  bit cur_us, cur_rw, cur_fault;

  always #10 clk = ~clk;

  tlb_front dut (.*);

  function automatic logic [19:0] frame_of(input logic [19:0] lpf);
    return lpf ^ 20'h5A5A5;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One lookup; stub walker answers from cur_* settings.
  task automatic access(input logic [31:0] la, input bit wr, input bit fe, input bit us, input bit wp,
                        output logic [31:0] pa, output bit flt, output int nw);
    bit got = 0;
    nw = 0; pa = '0; flt = 0;
    @(negedge clk);
    req_valid = 1; req_laddr = la; req_write = wr; req_fetch = fe; req_user = us; req_wp = wp;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 20; i++) begin
      if (rsp_valid) begin
        pa = rsp_paddr; flt = rsp_fault; got = 1; walk_done = 0;
        break;
      end
      if (walk_req && !walk_done) begin
        nw++;
        chk(walk_laddr == la, "R2 walk address", walk_laddr, la);
        chk(walk_write == (wr && !fe), "R5 walk write flag", 32'(walk_write), 32'(wr && !fe));
        chk(req_ready == 0, "R9 ready low during walk", 32'(req_ready), 0);
        walk_done = 1; walk_fault = cur_fault;
        walk_ppf = frame_of(walk_laddr[31:12]); walk_acc = {cur_us, cur_rw};
      end else begin
        walk_done = 0;
      end
      @(negedge clk);
    end
    chk(got, "R1 response arrives", 32'(got), 1);
  endtask

  task automatic expect_acc(input string tag, input logic [31:0] la, input bit wr, input bit fe,
                            input bit us, input bit wp, input int exp_walks, input bit exp_flt);
    logic [31:0] pa; bit flt; int nw;
    access(la, wr, fe, us, wp, pa, flt, nw);
    chk(nw == exp_walks, {tag, " walk count"}, 32'(nw), 32'(exp_walks));
    chk(flt == exp_flt, {tag, " fault flag"}, 32'(flt), 32'(exp_flt));
    if (!exp_flt)
      chk(pa == {frame_of(la[31:12]), la[11:0]}, {tag, " paddr"}, pa, {frame_of(la[31:12]), la[11:0]});
  endtask

  task automatic t_reset;
    chk(req_ready == 1, "R9 ready after reset", 32'(req_ready), 1);
    chk(rsp_valid == 0, "R7 no response after reset", 32'(rsp_valid), 0);
    chk(walk_req == 0, "R7 no walk after reset", 32'(walk_req), 0);
  endtask

  task automatic t_miss_hit;
    cur_us = 1; cur_rw = 1; cur_fault = 0;
    expect_acc("R7 frame0 misses after reset", 32'h0000_0123, 0, 0, 1, 0, 1, 0);
    expect_acc("R1 read hit new offset", 32'h0000_0ABC, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_dirty;
    expect_acc("R4 first write rewalks", 32'h0000_0010, 1, 0, 1, 0, 1, 0);
    expect_acc("R4 second write hits", 32'h0000_0020, 1, 0, 1, 0, 0, 0);
  endtask

  task automatic t_perm;
    cur_us = 0; cur_rw = 1;
    expect_acc("R3 supervisor read fill", 32'h0001_1000, 0, 0, 0, 0, 1, 0);
    cur_us = 1;
    expect_acc("R3 failed hit rewalks no fault", 32'h0001_1004, 0, 0, 1, 0, 1, 0);
    expect_acc("R3 user read now hits", 32'h0001_1008, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_wp;
    cur_us = 0; cur_rw = 0;
    expect_acc("R3 read-only page fill", 32'h0002_2000, 0, 0, 0, 0, 1, 0);
    expect_acc("R3 sup write wp0 rewalk", 32'h0002_2010, 1, 0, 0, 0, 1, 0);
    expect_acc("R3 sup write wp0 hits", 32'h0002_2020, 1, 0, 0, 0, 0, 0);
    cur_fault = 1;
    expect_acc("R6 sup write wp1 faults", 32'h0002_2030, 1, 0, 0, 1, 1, 1);
    cur_fault = 0;
    expect_acc("R6 entry invalid after fault", 32'h0002_2040, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_fetch;
    cur_us = 1; cur_rw = 0;
    expect_acc("R5 fetch with write flag fills", 32'h0003_3000, 1, 1, 1, 0, 1, 0);
    expect_acc("R5 fetch read-only page hits", 32'h0003_3004, 1, 1, 1, 0, 0, 0);
    cur_rw = 1;
    expect_acc("R5 write after fetch rewalks", 32'h0003_3008, 1, 0, 1, 0, 1, 0);
  endtask

  task automatic t_alias;
    cur_us = 1; cur_rw = 1;
    expect_acc("R8 first page", 32'h0004_4000, 0, 0, 1, 0, 1, 0);
    expect_acc("R8 alias page", 32'h1004_4000, 0, 0, 1, 0, 1, 0);
    expect_acc("R8 first page evicted", 32'h0004_4010, 0, 0, 1, 0, 1, 0);
    expect_acc("R8 other index kept", 32'h0003_300C, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_flush;
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    expect_acc("R7 flush drops kept page", 32'h0003_3010, 0, 0, 1, 0, 1, 0);
    expect_acc("R7 flush drops page zero", 32'h0000_0123, 0, 0, 1, 0, 1, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; flush = 0; req_valid = 0; req_laddr = '0; req_write = 0; req_fetch = 0;
    req_user = 0; req_wp = 0; walk_done = 0; walk_fault = 0; walk_ppf = '0; walk_acc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_miss_hit();
    t_dirty();
    t_perm();
    t_wp();
    t_fetch();
    t_alias();
    t_flush();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule